// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

The block is a read-only window onto a small set of byte-string configuration items kept in an on-chip table. Software first writes a 16-bit key that picks one item, then pulls that item's bytes through a data port, one byte or several bytes per access. An internal byte offset walks through the item. Once the item runs out, further reads return zeros.

The key holds an index and a bank bit. The bank bit chooses between a generic bank and an architecture-local bank, each with `NUM_ENTRIES` slots. Requests arrive on a simple register port that names one of three address spaces:

- a control space that takes the key;
- a data space that is up to `DATA_BYTES` wide;
- a combined two-byte window, where the access size decides whether the access is a select or a data access.

Every request is answered on the next cycle.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the selected key is 0 at offset 0. Item 0 of the generic bank is the four bytes 0x51, 0x45, 0x4D, 0x55, so a 4-byte data read then returns 0x51454D55.
- R2: Every accepted select sets the byte offset back to 0. This holds even when the key is the one already selected, so reading restarts at the item's first byte.
- R3: Key bit 14 chooses the bank (0 generic, 1 architecture-local) and key bits 13:0 give the index. An index at or above `NUM_ENTRIES` makes the selection invalid, and every data read then returns 0.
- R4: Item lengths are fixed. In the generic bank, index 0 has length 4. Every other entry has length (5*bank + 3*index) mod 7. Items are packed back to back in the table in the order generic 0..N-1, then local 0..N-1. Table byte a is 0x51, 0x45, 0x4D, 0x55 for a = 0..3 and (37*a + 11) mod 256 beyond that. A length-0 item reads as zeros.
- R5: A data read of N bytes takes up to N bytes starting at the current offset. The first byte lands in the most significant byte of the N-byte value, the bits above N bytes are 0, and the offset advances by one for each byte taken.
- R6: If the item ends partway through a read, the remaining low-order bytes are 0. A read that starts at or past the end returns 0 and leaves the offset where it was.
- R7: The control space (space code 0) accepts only 2-byte writes, which select the key held in `req_wdata`. Control reads and writes of any other size are illegal.
- R8: In the combined window (space code 2), a 1-byte read is a data read, a 1-byte write is ignored, and a 2-byte write is a select. Every other size or direction is illegal.
- R9: Data writes of a legal size are acknowledged and change nothing.
- R10: Every request is accepted (`req_ready` is 1). It is answered one cycle later by a single-cycle `resp_valid`. `resp_rdata` is 0 for any response that is not a data read, and also while `resp_valid` is low.
- R11: The data space (space code 1) accepts sizes 1 to `DATA_BYTES`. Other sizes, and space code 3, are illegal. An illegal access returns 0 and changes neither the key nor the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_space | input | 2 | 0 control, 1 data, 2 combined, 3 unmapped |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 16 | Key for select writes; ignored otherwise |
| resp_valid | output | 1 | Response, one cycle after the request |
| resp_rdata | output | 8*DATA_BYTES | Read data, most significant byte first |

## Verification
The bench targets the item end in several ways: a wide read that straddles the last byte, a read that starts exactly at the end, and a read of a zero-length item. A design that padded on the wrong side would return shifted bytes, and one that advanced the offset past the end would leak table bytes from the next item after a reselect. Bank selection and out-of-range indices are probed; a bank-bit decode error shows up as bytes from the wrong part of the table. Illegal control reads, undersized selects, wrong combined-window sizes and data writes are each followed by a read, so any stray change to the key or the offset appears as a wrong byte.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

    typedef enum logic [1:0] {
        SP_CTRL = 2'd0,
        SP_DATA = 2'd1,
        SP_COMB = 2'd2,
        SP_NONE = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_SELECT = 2'd1,
        OP_READ   = 2'd2,
        OP_WRITE  = 2'd3
    } op_e;

    localparam int KEY_W    = 16;
    localparam int BANK_BIT = 14;

    // Length of one item; the signature item is four bytes.
    function automatic int unsigned item_len(int unsigned bank, int unsigned idx);
        if (bank == 0 && idx == 0) return 4;
        return (bank * 5 + idx * 3) % 7;
    endfunction

    // Start of an item given its flat position (generic bank first).
    function automatic int unsigned item_start(int unsigned flat, int unsigned num);
        int unsigned acc;
        acc = 0;
        for (int unsigned f = 0; f < 2 * num; f++) begin
            if (f < flat) acc += item_len(f / num, f % num);
        end
        return acc;
    endfunction

    function automatic logic [7:0] rom_byte(int unsigned a);
        case (a)
            0:       return 8'h51;
            1:       return 8'h45;
            2:       return 8'h4D;
            3:       return 8'h55;
            default: return 8'((a * 37 + 11) % 256);
        endcase
    endfunction

endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
    import cfg_item_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter int SIZE_W     = 4
) (
    input  logic [1:0]        space,
    input  logic              write,
    input  logic [SIZE_W-1:0] size,
    output op_e               op,
    output logic [SIZE_W-1:0] rd_bytes
);
    always_comb begin
        op       = OP_NONE;
        rd_bytes = '0;
        case (space_e'(space))
            SP_CTRL: begin
                if (write && size == SIZE_W'(2)) op = OP_SELECT;
            end
            SP_DATA: begin
                if (size != '0 && int'(size) <= DATA_BYTES) begin
                    if (write) begin
                        op = OP_WRITE;
                    end else begin
                        op       = OP_READ;
                        rd_bytes = size;
                    end
                end
            end
            SP_COMB: begin
                if (size == SIZE_W'(1)) begin
                    if (write) begin
                        op = OP_WRITE;
                    end else begin
                        op       = OP_READ;
                        rd_bytes = SIZE_W'(1);
                    end
                end else if (size == SIZE_W'(2) && write) begin
                    op = OP_SELECT;
                end
            end
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/cfg_item_rom.sv
module cfg_item_rom
    import cfg_item_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int OFS_W       = 16,
    parameter int IDX_W       = 2
) (
    input  logic             bank,
    input  logic [IDX_W-1:0] idx,
    output logic [OFS_W-1:0] len,
    output logic [OFS_W-1:0] start
);
    localparam int TOTAL = 2 * NUM_ENTRIES;

    logic [OFS_W-1:0] len_tab   [TOTAL];
    logic [OFS_W-1:0] start_tab [TOTAL];

    for (genvar e = 0; e < TOTAL; e++) begin : g_ent
        assign len_tab[e]   = OFS_W'(item_len(e / NUM_ENTRIES, e % NUM_ENTRIES));
        assign start_tab[e] = OFS_W'(item_start(e, NUM_ENTRIES));
    end

    always_comb begin
        int flat;
        flat  = int'(bank) * NUM_ENTRIES + int'(idx);
        len   = '0;
        start = '0;
        if (int'(idx) < NUM_ENTRIES && flat < TOTAL) begin
            len   = len_tab[flat];
            start = start_tab[flat];
        end
    end
endmodule

// File: rtl/cfg_item_packer.sv
module cfg_item_packer
    import cfg_item_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter int OFS_W      = 16,
    parameter int SIZE_W     = 4
) (
    input  logic                    active,
    input  logic [OFS_W-1:0]        start,
    input  logic [OFS_W-1:0]        len,
    input  logic [OFS_W-1:0]        off,
    input  logic [SIZE_W-1:0]       size,
    output logic [8*DATA_BYTES-1:0] data,
    output logic [OFS_W-1:0]        next_off
);
    always_comb begin
        int unsigned taken;
        int unsigned pos;
        data  = '0;
        taken = 0;
        for (int k = 0; k < DATA_BYTES; k++) begin
            pos = int'(off) + k;
            if (active && k < int'(size) && pos < int'(len)) begin
                data[8*(int'(size)-1-k) +: 8] = rom_byte(int'(start) + pos);
                taken++;
            end
        end
        next_off = off + OFS_W'(taken);
    end
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
    import cfg_item_pkg::*;
#(
    parameter int DATA_BYTES  = 4,
    parameter int NUM_ENTRIES = 4,
    parameter int OFS_W       = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_space,
    input  logic                    req_write,
    input  logic [3:0]              req_size,
    input  logic [15:0]             req_wdata,
    output logic                    resp_valid,
    output logic [8*DATA_BYTES-1:0] resp_rdata
);
    localparam int DW     = 8 * DATA_BYTES;
    localparam int SIZE_W = 4;
    localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    typedef struct packed {
        logic             sel_ok;
        logic             bank;
        logic [IDX_W-1:0] idx;
        logic [OFS_W-1:0] off;
        logic             rsp_v;
        logic [DW-1:0]    rsp_d;
    } state_t;

    state_t            st_d, st_q;
    op_e               op;
    logic [SIZE_W-1:0] rd_bytes;
    logic [OFS_W-1:0]  cur_len, cur_start, pk_next;
    logic [DW-1:0]     pk_data;
    logic              pk_active;
    logic [BANK_BIT-1:0] key_idx;
    logic              unused_key_hi;

    assign key_idx       = req_wdata[BANK_BIT-1:0];
    assign unused_key_hi = req_wdata[KEY_W-1];

    cfg_access_decode #(.DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W)) u_dec (
        .space    (req_space),
        .write    (req_write),
        .size     (req_size),
        .op       (op),
        .rd_bytes (rd_bytes)
    );

    cfg_item_rom #(.NUM_ENTRIES(NUM_ENTRIES), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_rom (
        .bank  (st_q.bank),
        .idx   (st_q.idx),
        .len   (cur_len),
        .start (cur_start)
    );

    assign pk_active = req_valid && st_q.sel_ok && (op == OP_READ);

    cfg_item_packer #(.DATA_BYTES(DATA_BYTES), .OFS_W(OFS_W), .SIZE_W(SIZE_W)) u_pack (
        .active   (pk_active),
        .start    (cur_start),
        .len      (cur_len),
        .off      (st_q.off),
        .size     (rd_bytes),
        .data     (pk_data),
        .next_off (pk_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = req_valid;
        st_d.rsp_d = '0;
        if (req_valid) begin
            case (op)
                OP_SELECT: begin
                    st_d.off    = '0;
                    st_d.bank   = req_wdata[BANK_BIT];
                    st_d.sel_ok = (int'(key_idx) < NUM_ENTRIES);
                    st_d.idx    = IDX_W'(key_idx);
                end
                OP_READ: begin
                    st_d.rsp_d = pk_data;
                    st_d.off   = pk_next;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.sel_ok <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = 1'b1;
    assign resp_valid = st_q.rsp_v;
    assign resp_rdata = st_q.rsp_d;
endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
    parameter int DATA_BYTES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [1:0]              req_space,
    input logic                    req_write,
    input logic [3:0]              req_size,
    input logic                    resp_valid,
    input logic [8*DATA_BYTES-1:0] resp_rdata
);
    // R10
    ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
    // R10
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    // R10
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    // R10
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> resp_rdata == '0);
    // R9
    write_resp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> resp_rdata == '0);
    // R7
    ctrl_resp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_space == 2'd0) |=> resp_rdata == '0);
    // R8
    comb_wide_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_space == 2'd2 && req_size != 4'd1) |=> resp_rdata == '0);
    // R5
    byte_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 4'd1) |=> resp_rdata[8*DATA_BYTES-1:8] == '0);
endmodule

bind cfg_item_port cfg_item_port_chk #(.DATA_BYTES(DATA_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_space  (req_space),
    .req_write  (req_write),
    .req_size   (req_size),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata)
);

// File: tb/cfg_item_port_bench.sv
`timescale 1ns/100ps
module cfg_item_port_bench;
    localparam int NB = 4;
    localparam int NE = 4;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          req_valid = 0;
    logic          req_ready;
    logic [1:0]    req_space = 0;
    logic          req_write = 0;
    logic [3:0]    req_size = 0;
    logic [15:0]   req_wdata = 0;
    logic          resp_valid;
    logic [8*NB-1:0] resp_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference state
    bit m_ok;
    int m_bank, m_idx, m_off;

    always #2.5 clk = ~clk;

    cfg_item_port #(.DATA_BYTES(NB), .NUM_ENTRIES(NE)) u_cfg_item_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_space(req_space), .req_write(req_write), .req_size(req_size),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata)
    );

    function automatic int mlen(int b, int i);
        if (b == 0 && i == 0) return 4;
        return (5 * b + 3 * i) % 7;
    endfunction

    function automatic int mstart(int b, int i);
        int s = 0;
        for (int bb = 0; bb < 2; bb++)
            for (int ii = 0; ii < NE; ii++)
                if (bb * NE + ii < b * NE + i) s += mlen(bb, ii);
        return s;
    endfunction

    function automatic logic [7:0] mbyte(int a);
        byte unsigned sig [4] = '{8'h51, 8'h45, 8'h4D, 8'h55};
        if (a < 4) return sig[a];
        return 8'((37 * a + 11) % 256);
    endfunction

    task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(int n);
        logic [31:0] v = 0;
        int len = m_ok ? mlen(m_bank, m_idx) : 0;
        for (int k = 0; k < n; k++) begin
            v = v << 8;
            if (m_ok && m_off < len) begin
                v[7:0] = mbyte(mstart(m_bank, m_idx) + m_off);
                m_off++;
            end
        end
        return v;
    endfunction

    function automatic void model_select(logic [15:0] key);
        m_off  = 0;
        m_bank = key[14];
        m_idx  = int'(key[13:0]);
        m_ok   = m_idx < NE;
    endfunction

    // One request: drive at a falling edge, check the response one cycle later.
    task automatic access(input logic [1:0] sp, input bit wr, input int sz,
                          input logic [15:0] wd, input string tag);
        logic [31:0] exp = 0;
        if (sp == 2'd0) begin
            if (wr && sz == 2) model_select(wd);
        end else if (sp == 2'd1) begin
            if (sz >= 1 && sz <= NB && !wr) exp = model_read(sz);
        end else if (sp == 2'd2) begin
            if (sz == 1 && !wr) exp = model_read(1);
            else if (sz == 2 && wr) model_select(wd);
        end
        req_valid = 1; req_space = sp; req_write = wr; req_size = 4'(sz); req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        check(tag, resp_valid === 1'b1 && resp_rdata === exp, resp_rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_ok = 1; m_bank = 0; m_idx = 0; m_off = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual %h expected %h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10: reset state of the response side
        check("R10", resp_valid === 1'b0 && resp_rdata === '0 && req_ready === 1'b1, {31'b0, resp_valid}, 0);
        // R1: signature after reset
        access(2'd1, 0, 4, 0, "R1");
        // R6: read starting at end
        access(2'd1, 0, 1, 0, "R6");
        // R7 / R5 / R6: select key 1 (length 3), 4-byte read pads
        access(2'd0, 1, 2, 16'h0001, "R7");
        access(2'd1, 0, 4, 0, "R6");
        access(2'd1, 0, 2, 0, "R6");
        // R5: key 2, length 6, mixed sizes
        access(2'd0, 1, 2, 16'h0002, "R7");
        access(2'd1, 0, 2, 0, "R5");
        access(2'd1, 0, 1, 0, "R5");
        // R2 / R8: reselect through combined window restarts
        access(2'd2, 1, 2, 16'h0002, "R8");
        access(2'd1, 0, 3, 0, "R2");
        // R7: illegal control accesses leave state alone
        access(2'd0, 0, 2, 0, "R7");
        access(2'd0, 1, 1, 16'h0000, "R7");
        access(2'd0, 1, 4, 16'h0000, "R7");
        access(2'd1, 0, 1, 0, "R7");
        // R9: data write has no effect
        access(2'd1, 1, 4, 16'hFFFF, "R9");
        access(2'd1, 0, 1, 0, "R9");
        // R11: illegal sizes and unmapped space
        access(2'd1, 0, 5, 0, "R11");
        access(2'd1, 0, 0, 0, "R11");
        access(2'd3, 0, 1, 0, "R11");
        access(2'd3, 1, 2, 16'h0001, "R11");
        access(2'd1, 0, 4, 0, "R11");
        // R3: architecture-local bank
        access(2'd0, 1, 2, 16'h4001, "R3");
        access(2'd1, 0, 2, 0, "R3");
        access(2'd0, 1, 2, 16'h4000, "R3");
        access(2'd1, 0, 4, 0, "R3");
        access(2'd1, 0, 4, 0, "R6");
        // R4: zero-length item
        access(2'd0, 1, 2, 16'h4003, "R4");
        access(2'd1, 0, 4, 0, "R4");
        // R3: out-of-range indices
        access(2'd0, 1, 2, 16'h0005, "R3");
        access(2'd1, 0, 4, 0, "R3");
        access(2'd0, 1, 2, 16'h4004, "R3");
        access(2'd2, 0, 1, 0, "R3");
        // R8: combined window byte reads through key 0x4002
        access(2'd2, 1, 2, 16'h4002, "R8");
        for (int i = 0; i < 5; i++) access(2'd2, 0, 1, 0, "R8");
        access(2'd2, 1, 2, 16'h0003, "R8");
        access(2'd2, 1, 1, 16'h00AA, "R8");
        access(2'd2, 0, 2, 0, "R8");
        access(2'd2, 1, 4, 16'h0001, "R8");
        access(2'd2, 0, 1, 0, "R8");
        access(2'd1, 0, 4, 0, "R4");
        // R10: idle cycle gives no response
        @(negedge clk);
        check("R10", resp_valid === 1'b0 && resp_rdata === '0, resp_rdata, 0);
        // R1: reset mid-item returns to the signature
        access(2'd0, 1, 2, 16'h0002, "R7");
        access(2'd1, 0, 1, 0, "R5");
        do_reset();
        access(2'd1, 0, 2, 0, "R1");
        access(2'd1, 0, 3, 0, "R1");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule